// File: doc/BRIEF.md
# Fixed-Point Status Flag Unit

This block turns the operands and the 64-bit result of an integer operation into the status flags that a fixed-point pipeline keeps: the carry bits for the full width and for the low half, the overflow bits for the same two widths, a sticky summary-overflow bit, and a four-bit condition nibble. It does not do the arithmetic. The execution stage supplies the result beside the operands it used, along with per-operation controls. These controls say whether carry, overflow or the condition nibble should be written, whether the operation is an add, whether the first operand was inverted, and whether an immediate took part.

Carry is found without the adder's carry chain. A carry is reported when any operand, taken as an unsigned number, is larger than the result. Add operations are the exception for the half-width carry: it is taken from bit 32 of the first operand, the second operand and the result. An operation that writes a carry bit itself masks that bit here. Overflow comes from the sign rule on the first two operands, or from a divider's own overflow verdict when one is presented. The unit registers everything on a single update strobe, and each flag group that is not enabled keeps its value.

Top module: `fxflag_unit`

## Requirements
- R1: After reset every output (`ca`, `ca32`, `ov`, `ov32`, `so`, `cr0`) is 0.
- R2: Flags change only in a cycle where `upd_vld` is high. The carry pair changes only when `carry_en` is set, overflow/OV32/SO only when `ovf_en` is set, and `cr0` only when `rec_en` is set.
- R3: The operand list is: operand A (bitwise inverted first when `inv_a` is 1), then B when `op_b_vld` is 1, then `imm` when `imm_vld` is 1.
- R4: The next `ca` is 1 exactly when some operand in the list is unsigned-greater than the full 64-bit `res`.
- R5: When `is_add` is 1, the next `ca32` is the XOR of bit 32 of `res`, bit 32 of the effective A, and bit 32 of the second operand. The second operand is B if present, otherwise `imm` if present, otherwise 0.
- R6: When `is_add` is 0, the next `ca32` is 1 exactly when some operand's bits 31..0 are unsigned-greater than bits 31..0 of `res`.
- R7: `skip_mask[0]` set keeps `ca` unchanged and `skip_mask[1]` set keeps `ca32` unchanged, even while `carry_en` is 1.
- R8: Without a division overflow, `ov` is 1 when the first two operands share a sign (bit 63) and the sign of `res` differs from it. `ov32` is the same test on bit 31. With fewer than two operands, both keep their values.
- R9: When `div_ovf_vld` is 1 with `ovf_en`, both `ov` and `ov32` take the value of `div_ovf`.
- R10: Whenever `ov` is written, `so` becomes `so` OR the new `ov`. Once set, `so` stays 1 until reset.
- R11: With `rec_en`, `cr0` is {negative, positive, zero, so}, bit 3 down to bit 0. The three tests treat `res` as signed, and the `so` value is the one produced by the same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_vld | input | 1 | Update strobe for one completed operation |
| op_a | input | 64 | First operand |
| inv_a | input | 1 | Invert first operand before evaluation |
| op_b | input | 64 | Second register operand |
| op_b_vld | input | 1 | Second register operand present |
| imm | input | 64 | Immediate operand |
| imm_vld | input | 1 | Immediate operand present |
| res | input | 64 | Operation result |
| is_add | input | 1 | Operation is an add (selects half-width carry rule) |
| carry_en | input | 1 | Write carry flags |
| skip_mask | input | 2 | Bit 0 keeps ca, bit 1 keeps ca32 |
| ovf_en | input | 1 | Write overflow flags and SO |
| div_ovf_vld | input | 1 | Division overflow verdict present |
| div_ovf | input | 1 | Division overflow verdict |
| rec_en | input | 1 | Write the condition nibble |
| ca | output | 1 | Full-width carry |
| ca32 | output | 1 | Half-width carry |
| ov | output | 1 | Full-width overflow |
| ov32 | output | 1 | Half-width overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition nibble {neg, pos, zero, so} |

## Verification
On every cycle the assertions check several properties of the registered flags. Flags hold without a strobe or an enable, each skip bit holds its carry, and a division verdict lands in both overflow bits. `so` never falls, and a recorded nibble has exactly one of its three sign bits set and repeats `so` in bit 0. The values themselves need the bench's reference model and its scenarios. These cover the unsigned-compare carries, the add-specific half carry, a missing second operand, the sign-rule overflow at both widths, an immediate standing in as an operand, and the inverted first operand.

// File: rtl/fxflag_pkg.sv
package fxflag_pkg;
  localparam int unsigned FX_W     = 64;
  localparam int unsigned FX_NSLOT = 3;   // A, B, immediate
  localparam int unsigned FX_NLANE = 2;   // half-width lane, full-width lane

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } fx_flags_t;
endpackage

// File: rtl/fxflag_carry.sv
module fxflag_carry #(
  parameter int unsigned W     = 64,
  parameter int unsigned NSLOT = 3
) (
  input  logic [NSLOT-1:0][W-1:0] slot,
  input  logic [NSLOT-1:0]        slot_vld,
  input  logic [W-1:0]            res,
  input  logic                    sec_mid,
  input  logic                    is_add,
  output logic                    ca_n,
  output logic                    ca32_n
);
  localparam int unsigned HALF = W / 2;

  logic [NSLOT-1:0] gt_full;
  logic [NSLOT-1:0] gt_low;
  logic             mid_xor;

  // one unsigned comparator pair per operand slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign gt_full[g] = slot_vld[g] && (slot[g] > res);
    assign gt_low[g]  = slot_vld[g] && (slot[g][HALF-1:0] > res[HALF-1:0]);
  end

  always_comb begin
    mid_xor = res[HALF] ^ slot[0][HALF] ^ sec_mid;
    ca_n    = |gt_full;
    ca32_n  = is_add ? mid_xor : (|gt_low);
  end
endmodule

// File: rtl/fxflag_ovf.sv
module fxflag_ovf #(
  parameter int unsigned NLANE = 2
) (
  input  logic [NLANE-1:0] a_sgn,
  input  logic [NLANE-1:0] b_sgn,
  input  logic [NLANE-1:0] r_sgn,
  output logic [NLANE-1:0] ovf
);
  // lane 0 looks at the half-width sign, lane 1 at the full-width sign
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign ovf[g] = (a_sgn[g] == b_sgn[g]) && (r_sgn[g] != a_sgn[g]);
  end
endmodule

// File: rtl/fxflag_cond.sv
module fxflag_cond #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         pos,
  output logic         zero
);
  always_comb begin
    zero = (res == '0);
    neg  = res[W-1];
    pos  = !neg && !zero;
  end
endmodule

// File: rtl/fxflag_unit.sv
module fxflag_unit
  import fxflag_pkg::*;
#(
  parameter int unsigned W = FX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_vld,
  input  logic [W-1:0] op_a,
  input  logic         inv_a,
  input  logic [W-1:0] op_b,
  input  logic         op_b_vld,
  input  logic [W-1:0] imm,
  input  logic         imm_vld,
  input  logic [W-1:0] res,
  input  logic         is_add,
  input  logic         carry_en,
  input  logic [1:0]   skip_mask,
  input  logic         ovf_en,
  input  logic         div_ovf_vld,
  input  logic         div_ovf,
  input  logic         rec_en,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         ov32,
  output logic         so,
  output logic [3:0]   cr0
);
  localparam int unsigned HALF  = W / 2;
  localparam int unsigned NSLOT = FX_NSLOT;
  localparam int unsigned NLANE = FX_NLANE;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       run_q;
  logic       upd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign run_q  = rst_pipe[1];
  assign upd_go = upd_vld && run_q;

  // ---------------- operand list ----------------
  logic [W-1:0]                a_eff;
  logic [NSLOT-1:0][W-1:0]     slot;
  logic [NSLOT-1:0]            slot_vld;
  logic                        two_ops;
  logic                        sec_mid;
  logic [NLANE-1:0]            a_sgn, b_sgn, r_sgn;

  always_comb begin
    a_eff    = inv_a ? ~op_a : op_a;
    slot[0]  = a_eff;
    slot[1]  = op_b;
    slot[2]  = imm;
    slot_vld = {imm_vld, op_b_vld, 1'b1};
    two_ops  = op_b_vld || imm_vld;
    sec_mid  = op_b_vld ? op_b[HALF] : (imm_vld ? imm[HALF] : 1'b0);
    a_sgn    = {a_eff[W-1], a_eff[HALF-1]};
    b_sgn    = op_b_vld ? {op_b[W-1], op_b[HALF-1]} : {imm[W-1], imm[HALF-1]};
    r_sgn    = {res[W-1], res[HALF-1]};
  end

  // ---------------- flag logic ----------------
  logic             ca_n, ca32_n;
  logic [NLANE-1:0] ovf_lane;
  logic             neg, pos, zero;

  fxflag_carry #(.W(W), .NSLOT(NSLOT)) u_carry (
    .slot     (slot),
    .slot_vld (slot_vld),
    .res      (res),
    .sec_mid  (sec_mid),
    .is_add   (is_add),
    .ca_n     (ca_n),
    .ca32_n   (ca32_n)
  );

  fxflag_ovf #(.NLANE(NLANE)) u_ovf (
    .a_sgn (a_sgn),
    .b_sgn (b_sgn),
    .r_sgn (r_sgn),
    .ovf   (ovf_lane)
  );

  fxflag_cond #(.W(W)) u_cond (
    .res  (res),
    .neg  (neg),
    .pos  (pos),
    .zero (zero)
  );

  // ---------------- next state ----------------
  fx_flags_t  flg_q, flg_d;
  logic [3:0] cr0_q, cr0_d;

  always_comb begin
    flg_d = flg_q;
    cr0_d = cr0_q;
    if (carry_en) begin
      if (!skip_mask[0]) flg_d.ca   = ca_n;
      if (!skip_mask[1]) flg_d.ca32 = ca32_n;
    end
    if (ovf_en) begin
      if (div_ovf_vld) begin
        flg_d.ov   = div_ovf;
        flg_d.ov32 = div_ovf;
        flg_d.so   = flg_q.so | div_ovf;
      end else if (two_ops) begin
        flg_d.ov   = ovf_lane[1];
        flg_d.ov32 = ovf_lane[0];
        flg_d.so   = flg_q.so | ovf_lane[1];
      end
    end
    if (rec_en) cr0_d = {neg, pos, zero, flg_d.so};
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      cr0_q <= '0;
    end else if (upd_go) begin
      flg_q <= flg_d;
      cr0_q <= cr0_d;
    end
  end

  assign ca   = flg_q.ca;
  assign ca32 = flg_q.ca32;
  assign ov   = flg_q.ov;
  assign ov32 = flg_q.ov32;
  assign so   = flg_q.so;
  assign cr0  = cr0_q;

  // ---------------- assertions ----------------
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> ($stable(ca) && $stable(ca32) && $stable(ov) && $stable(ov32)
                  && $stable(so) && $stable(cr0)));

  assert_hold_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !carry_en) |=> ($stable(ca) && $stable(ca32)));

  assert_hold_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !rec_en) |=> $stable(cr0));

  assert_skip_ca_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && skip_mask[0]) |=> $stable(ca));

  assert_skip_ca32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && skip_mask[1]) |=> $stable(ca32));

  assert_div_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && ovf_en && div_ovf_vld) |=> (ov == $past(div_ovf) && ov32 == $past(div_ovf)));

  assert_so_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);

  assert_cond_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && rec_en) |=> ($countones(cr0[3:1]) == 1 && cr0[0] == so));
endmodule

// File: tb/sim_fxflag_unit.sv
module sim_fxflag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_vld = 1'b0;
  logic [63:0] op_a = '0, op_b = '0, imm = '0, res = '0;
  logic        inv_a = 1'b0, op_b_vld = 1'b0, imm_vld = 1'b0, is_add = 1'b0;
  logic        carry_en = 1'b0, ovf_en = 1'b0, div_ovf_vld = 1'b0, div_ovf = 1'b0, rec_en = 1'b0;
  logic [1:0]  skip_mask = 2'b00;
  logic        ca, ca32, ov, ov32, so;
  logic [3:0]  cr0;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 0;
  bit done = 0;
  string cur_tag = "R1";
  string last_tag = "R1";

  // reference state
  bit m_ca, m_ca32, m_ov, m_ov32, m_so;
  bit [3:0] m_cr0;
  int rcnt;

  always #10 clk = ~clk;   // 50 MHz

  fxflag_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .op_a(op_a), .inv_a(inv_a),
    .op_b(op_b), .op_b_vld(op_b_vld), .imm(imm), .imm_vld(imm_vld), .res(res),
    .is_add(is_add), .carry_en(carry_en), .skip_mask(skip_mask), .ovf_en(ovf_en),
    .div_ovf_vld(div_ovf_vld), .div_ovf(div_ovf), .rec_en(rec_en),
    .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
  );

  task automatic model_step();
    bit [63:0] ops[$];
    bit [63:0] second;
    bit c, upd_ov;
    longint sres;
    ops.push_back(inv_a ? ~op_a : op_a);
    if (op_b_vld) ops.push_back(op_b);
    if (imm_vld)  ops.push_back(imm);
    if (carry_en) begin
      c = 0;
      foreach (ops[i]) if (ops[i] > res) c = 1;
      if (!skip_mask[0]) m_ca = c;
      if (is_add) begin
        second = (ops.size() >= 2) ? ops[1] : 64'd0;
        c = res[32] ^ ops[0][32] ^ second[32];
      end else begin
        c = 0;
        foreach (ops[i]) if (ops[i][31:0] > res[31:0]) c = 1;
      end
      if (!skip_mask[1]) m_ca32 = c;
    end
    if (ovf_en) begin
      upd_ov = 0;
      if (div_ovf_vld) begin
        m_ov = div_ovf; m_ov32 = div_ovf; upd_ov = 1;
      end else if (ops.size() >= 2) begin
        m_ov   = ($signed(ops[0]) < 0) == ($signed(ops[1]) < 0) &&
                 (($signed(res) < 0) != ($signed(ops[0]) < 0));
        m_ov32 = ($signed(ops[0][31:0]) < 0) == ($signed(ops[1][31:0]) < 0) &&
                 (($signed(res[31:0]) < 0) != ($signed(ops[0][31:0]) < 0));
        upd_ov = 1;
      end
      if (upd_ov) m_so = m_so | m_ov;
    end
    if (rec_en) begin
      sres = res;
      m_cr0 = {sres < 0, sres > 0, sres == 0, m_so};
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr0 = 4'h0;
      rcnt = 0;
      last_tag = "R1";
    end else begin
      last_tag = cur_tag;
      if (upd_vld && rcnt >= 2) model_step();
      if (rcnt < 2) rcnt = rcnt + 1;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if ({ca, ca32, ov, ov32, so, cr0} !== {m_ca, m_ca32, m_ov, m_ov32, m_so, m_cr0}) begin
        n_err++;
        $display("FAIL %s flags actual=%b expected=%b", last_tag,
                 {ca, ca32, ov, ov32, so, cr0}, {m_ca, m_ca32, m_ov, m_ov32, m_so, m_cr0});
      end
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {ca, ca32, ov, ov32, so, cr0};
  endfunction

  task automatic op(string tag, logic [63:0] a, logic ia, logic [63:0] b, logic bv,
                    logic [63:0] im, logic iv, logic [63:0] r, logic add, logic cen,
                    logic [1:0] sk, logic oen, logic dv, logic d, logic ren);
    @(posedge clk); #5;
    cur_tag = tag;
    op_a = a; inv_a = ia; op_b = b; op_b_vld = bv; imm = im; imm_vld = iv; res = r;
    is_add = add; carry_en = cen; skip_mask = sk; ovf_en = oen;
    div_ovf_vld = dv; div_ovf = d; rec_en = ren; upd_vld = 1'b1;
    @(posedge clk); #3;
    upd_vld = 1'b0;
    #5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  initial begin
    do_reset();
    cmp_on = 1;
    #1 chk("R1", outs(), 9'b0);

    // R2: garbage on inputs without the strobe
    cur_tag = "R2";
    op_a = ONES; op_b = 1; op_b_vld = 1; res = 0; carry_en = 1; ovf_en = 1; rec_en = 1;
    div_ovf_vld = 1; div_ovf = 1;
    repeat (3) @(posedge clk);
    #8 chk("R2", outs(), 9'b0);
    div_ovf_vld = 0; div_ovf = 0;

    // carries: ca ca32 ov ov32 so cr0
    op("R4", 64'd0, 0, 64'd0, 1, 0, 0, 64'd5, 0, 1, 2'b00, 0, 0, 0, 0);
    chk("R4", outs(), 9'b00_000_0000);
    op("R3", 64'd0, 1, 64'd1, 1, 0, 0, 64'd0, 0, 1, 2'b00, 0, 0, 0, 0);
    chk("R3", outs(), 9'b11_000_0000);
    op("R3", 64'd0, 0, 64'd1, 1, 0, 0, 64'd5, 0, 1, 2'b00, 0, 0, 0, 0);
    chk("R3", outs(), 9'b00_000_0000);
    op("R3", 64'd5, 0, 0, 0, 64'd10, 1, 64'd7, 0, 1, 2'b00, 0, 0, 0, 0);
    chk("R3", outs(), 9'b11_000_0000);
    op("R6", 64'h0000_0000_FFFF_FFFF, 0, 0, 0, 0, 0, 64'h1_0000_0000, 0, 1, 2'b00, 0, 0, 0, 0);
    chk("R6", outs(), 9'b01_000_0000);
    op("R4", ONES, 0, 64'd1, 1, 0, 0, 64'd0, 1, 1, 2'b00, 0, 0, 0, 0);
    chk("R5", outs(), 9'b11_000_0000);
    op("R5", 64'h1_0000_0000, 0, 0, 0, 0, 0, 64'h1_0000_0000, 1, 1, 2'b00, 0, 0, 0, 0);
    chk("R5", outs(), 9'b00_000_0000);
    op("R7", ONES, 0, 64'd1, 1, 0, 0, 64'd0, 1, 1, 2'b01, 0, 0, 0, 0);
    chk("R7", outs(), 9'b01_000_0000);
    op("R7", 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, 64'd1, 0, 1, 2'b10, 0, 0, 0, 0);
    chk("R7", outs(), 9'b11_000_0000);
    op("R2", 64'd0, 0, 64'd0, 1, 0, 0, 64'd5, 0, 0, 2'b00, 0, 0, 0, 0);
    chk("R2", outs(), 9'b11_000_0000);

    // overflow
    op("R8", MAXP, 0, 64'd1, 1, 0, 0, MINN, 1, 0, 2'b00, 1, 0, 0, 0);
    chk("R8", outs(), 9'b11_101_0000);
    op("R8", MAXP, 0, 0, 0, 0, 0, 64'd0, 0, 0, 2'b00, 1, 0, 0, 0);
    chk("R8", outs(), 9'b11_101_0000);
    op("R10", 64'h0000_0000_7FFF_FFFF, 0, 64'd1, 1, 0, 0, 64'h0000_0000_8000_0000, 1, 0, 2'b00, 1, 0, 0, 0);
    chk("R10", outs(), 9'b11_011_0000);
    op("R9", 64'd0, 0, 64'd0, 1, 0, 0, 64'd0, 0, 0, 2'b00, 1, 1, 1, 0);
    chk("R9", outs(), 9'b11_111_0000);
    op("R9", 64'd0, 0, 64'd0, 1, 0, 0, 64'd0, 0, 0, 2'b00, 1, 1, 0, 0);
    chk("R9", outs(), 9'b11_001_0000);
    op("R2", MAXP, 0, 64'd1, 1, 0, 0, MINN, 0, 0, 2'b00, 0, 0, 0, 0);
    chk("R2", outs(), 9'b11_001_0000);

    // condition nibble
    op("R11", 0, 0, 0, 0, 0, 0, MINN, 0, 0, 2'b00, 0, 0, 0, 1);
    chk("R11", outs(), 9'b11_001_1001);
    op("R11", 0, 0, 0, 0, 0, 0, 64'd0, 0, 0, 2'b00, 0, 0, 0, 1);
    chk("R11", outs(), 9'b11_001_0011);
    op("R11", 0, 0, 0, 0, 0, 0, 64'd5, 0, 0, 2'b00, 0, 0, 0, 1);
    chk("R11", outs(), 9'b11_001_0101);

    // fresh reset clears the sticky bit
    cmp_on = 0;
    do_reset();
    cmp_on = 1;
    #1 chk("R1", outs(), 9'b0);
    op("R11", MAXP, 0, 64'd1, 1, 0, 0, MINN, 1, 0, 2'b00, 1, 0, 0, 1);
    chk("R11", outs(), 9'b00_101_1001);

    // mixed random traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra, rb, ri, rr;
      logic [4:0]  sel;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      ri = {$urandom, $urandom};
      sel = 5'($urandom);
      rr = sel[0] ? ra + rb : {$urandom, $urandom};
      if (sel[4:1] == 4'd0) rr = 64'd0;
      op("R4", ra, sel[1], rb, sel[2], ri, sel[3], rr, sel[4], 1'($urandom),
         2'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule